// File: doc/BRIEF.md
# Registered Signed Complex Multiplier

This block forms the product of two complex operands, X = x_re + j·x_im and Y = y_re + j·y_im. Every component is a W-bit two's complement integer. The real result is x_re·y_re − x_im·y_im and the imaginary result is x_re·y_im + x_im·y_re. Each result is 2W bits wide, and each carries its own overflow flag. The block is meant to sit inside a fixed-point FFT datapath as the twiddle rotation step.

The operands are captured in a rank of edge-triggered flip-flops. The four products and the subtract/add step lie between that rank and a second rank, which holds both results and both flags. A new operand set can enter on every rising edge, and its results leave two edges later. One synchronous, active-high reset clears both ranks. The combinational path between the ranks is one multiplier followed by one adder. That path has to fit in a 10 ns cycle or less.

Top module: `cplx_mul_reg`

## Requirements
- R1: `p_re` equals the low 2W bits of the exact value x_re·y_re − x_im·y_im, with all operands read as two's complement.
- R2: `p_im` equals the low 2W bits of the exact value x_re·y_im + x_im·y_re, with all operands read as two's complement.
- R3: `p_re_ovf` is 1 exactly when the exact real result lies outside the signed 2W-bit range. For operands that are W-bit two's complement values this never happens, so the flag stays 0.
- R4: `p_im_ovf` is 1 exactly when the exact imaginary result lies outside the signed 2W-bit range. That happens only when all four components are the most negative value. In that case `p_im` shows the wrapped pattern: a 1 in bit 2W−1 and zeros below it.
- R5: Operands present at rising edge k appear on the outputs after rising edge k+1. After edge k alone, the outputs still show the previous operand set. A new operand set is accepted on every edge.
- R6: A rising edge with `rst` = 1 clears both register ranks. All four outputs read 0 after that edge, and they read 0 after the first edge following release. Operands applied while `rst` = 1 never reach the outputs.
- R7: With W = 4 and operands x_re = −7, x_im = −6, y_re = −7, y_im = −6, the outputs are `p_re` = 00001101 (+13) and `p_im` = 01010100 (+84), and both flags are 0.
- R8: With W = 4 and every component at −8, the outputs are `p_re` = 0, `p_im` = 8'h80, `p_re_ovf` = 0 and `p_im_ovf` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both register ranks |
| rst | input | 1 | Synchronous active-high clear of both ranks |
| x_re | input | W | Real component of operand X |
| x_im | input | W | Imaginary component of operand X |
| y_re | input | W | Real component of operand Y |
| y_im | input | W | Imaginary component of operand Y |
| p_re | output | 2W | Registered real result |
| p_im | output | 2W | Registered imaginary result |
| p_re_ovf | output | 1 | Overflow of the real result |
| p_im_ovf | output | 1 | Overflow of the imaginary result |

## Verification
Two events can land in the same cycle. One is the imaginary overflow, with the wrapped result. The other is a reset that cuts a full pipeline short.

The bench sweeps all 65,536 operand sets of a 4-bit instance, one per cycle. The all-most-negative set passes through the pipeline next to ordinary sets, so its flag must rise and fall cycle by cycle. Reset pulses are inserted into the stream with non-zero operands on the inputs. A register model in the bench decides, for every sampled cycle, whether the output is judged as an arithmetic result or as a cleared value.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Selects the combining operation that follows a pair of products
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } cmul_op_e;

endpackage

// File: rtl/cmul_pipe_reg.sv
// Rank of D flip-flops with synchronous active-high clear
module cmul_pipe_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/cmul_smul.sv
// Signed W x W multiplier producing the full 2W-bit product
module cmul_smul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] prod;

  assign a_ext = PW'($signed(a));
  assign b_ext = PW'($signed(b));
  assign prod  = a_ext * b_ext;
  assign p     = prod;

endmodule

// File: rtl/cmul_addsub.sv
// Combines two signed products, reporting loss of the top bit
module cmul_addsub
  import cmul_pkg::*;
#(
  parameter int       PW = 32,
  parameter cmul_op_e OP = OP_ADD
) (
  input  logic [PW-1:0] lhs,
  input  logic [PW-1:0] rhs,
  output logic [PW-1:0] res,
  output logic          ovf
);

  logic signed [PW:0] lhs_x;
  logic signed [PW:0] rhs_x;
  logic signed [PW:0] wide;

  assign lhs_x = {lhs[PW-1], lhs};
  assign rhs_x = {rhs[PW-1], rhs};

  generate
    if (OP == OP_SUB) begin : g_sub
      assign wide = lhs_x - rhs_x;
    end else begin : g_add
      assign wide = lhs_x + rhs_x;
    end
  endgenerate

  assign res = wide[PW-1:0];
  assign ovf = wide[PW] ^ wide[PW-1];

endmodule

// File: rtl/cplx_mul_reg.sv
// Two-rank pipelined signed complex multiplier
module cplx_mul_reg
  import cmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   x_re,
  input  logic [W-1:0]   x_im,
  input  logic [W-1:0]   y_re,
  input  logic [W-1:0]   y_im,
  output logic [2*W-1:0] p_re,
  output logic [2*W-1:0] p_im,
  output logic           p_re_ovf,
  output logic           p_im_ovf
);

  localparam int PW    = 2 * W;
  localparam int IN_W  = 4 * W;
  localparam int OUT_W = 2 * PW + 2;
  localparam int NMUL  = 4;

  // Input rank
  logic [IN_W-1:0] in_q;
  logic [W-1:0]    a_q, b_q, c_q, d_q;

  cmul_pipe_reg #(.WIDTH(IN_W)) u_in_rank (
    .clk (clk),
    .rst (rst),
    .d   ({x_re, x_im, y_re, y_im}),
    .q   (in_q)
  );

  assign a_q = in_q[4*W-1:3*W];
  assign b_q = in_q[3*W-1:2*W];
  assign c_q = in_q[2*W-1:W];
  assign d_q = in_q[W-1:0];

  // Product array: 0 = ac, 1 = bd, 2 = ad, 3 = bc
  logic [W-1:0]  m_l [NMUL];
  logic [W-1:0]  m_r [NMUL];
  logic [PW-1:0] prod [NMUL];

  assign m_l[0] = a_q;  assign m_r[0] = c_q;
  assign m_l[1] = b_q;  assign m_r[1] = d_q;
  assign m_l[2] = a_q;  assign m_r[2] = d_q;
  assign m_l[3] = b_q;  assign m_r[3] = c_q;

  generate
    for (genvar g = 0; g < NMUL; g++) begin : g_mul
      cmul_smul #(.W(W)) u_mul (
        .a (m_l[g]),
        .b (m_r[g]),
        .p (prod[g])
      );
    end
  endgenerate

  // Combine stage
  logic [PW-1:0] re_c, im_c;
  logic          re_ovf_c, im_ovf_c;

  cmul_addsub #(.PW(PW), .OP(OP_SUB)) u_real (
    .lhs (prod[0]),
    .rhs (prod[1]),
    .res (re_c),
    .ovf (re_ovf_c)
  );

  cmul_addsub #(.PW(PW), .OP(OP_ADD)) u_imag (
    .lhs (prod[2]),
    .rhs (prod[3]),
    .res (im_c),
    .ovf (im_ovf_c)
  );

  // Output rank
  logic [OUT_W-1:0] out_q;

  cmul_pipe_reg #(.WIDTH(OUT_W)) u_out_rank (
    .clk (clk),
    .rst (rst),
    .d   ({re_ovf_c, im_ovf_c, re_c, im_c}),
    .q   (out_q)
  );

  assign p_re_ovf = out_q[OUT_W-1];
  assign p_im_ovf = out_q[OUT_W-2];
  assign p_re     = out_q[2*PW-1:PW];
  assign p_im     = out_q[PW-1:0];

endmodule

// File: rtl/cplx_mul_reg_chk.sv
// Wide-precision checker bound to the complex multiplier
module cplx_mul_reg_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   x_re,
  input logic [W-1:0]   x_im,
  input logic [W-1:0]   y_re,
  input logic [W-1:0]   y_im,
  input logic [2*W-1:0] p_re,
  input logic [2*W-1:0] p_im,
  input logic           p_re_ovf,
  input logic           p_im_ovf
);

  localparam int PW = 2 * W;
  localparam int XW = PW + 2;

  function automatic logic signed [XW-1:0] ext(input logic [W-1:0] v);
    return XW'($signed(v));
  endfunction

  function automatic logic fits(input logic [XW-1:0] v);
    return (v[XW-1:PW-1] == '0) || (v[XW-1:PW-1] == '1);
  endfunction

  logic [W-1:0]          s_a, s_b, s_c, s_d;
  logic signed [XW-1:0]  r_re, r_im;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_a <= '0; s_b <= '0; s_c <= '0; s_d <= '0;
      r_re <= '0; r_im <= '0;
    end else begin
      s_a <= x_re; s_b <= x_im; s_c <= y_re; s_d <= y_im;
      r_re <= ext(s_a) * ext(s_c) - ext(s_b) * ext(s_d);
      r_im <= ext(s_a) * ext(s_d) + ext(s_b) * ext(s_c);
    end
  end

  // R1
  real_value_chk: assert property (@(posedge clk) disable iff (rst)
    p_re == r_re[PW-1:0]);

  // R2
  imag_value_chk: assert property (@(posedge clk) disable iff (rst)
    p_im == r_im[PW-1:0]);

  // R3
  real_flag_chk: assert property (@(posedge clk) disable iff (rst)
    p_re_ovf == !fits(r_re));

  // R3
  real_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !p_re_ovf);

  // R4
  imag_flag_chk: assert property (@(posedge clk) disable iff (rst)
    p_im_ovf == !fits(r_im));

  // R4
  imag_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    p_im_ovf |-> (p_im == {1'b1, {(PW-1){1'b0}}}));

  // R6
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (p_re == '0 && p_im == '0 && !p_re_ovf && !p_im_ovf));

endmodule

bind cplx_mul_reg cplx_mul_reg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .x_re     (x_re),
  .x_im     (x_im),
  .y_re     (y_re),
  .y_im     (y_im),
  .p_re     (p_re),
  .p_im     (p_im),
  .p_re_ovf (p_re_ovf),
  .p_im_ovf (p_im_ovf)
);

// File: tb/cplx_mul_reg_bench.sv
module cplx_mul_reg_bench;

  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  x_re = '0, x_im = '0, y_re = '0, y_im = '0;
  logic [PW-1:0] p_re, p_im;
  logic          p_re_ovf, p_im_ovf;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cplx_mul_reg #(.W(W)) u_cplx_mul_reg (
    .clk      (clk),
    .rst      (rst),
    .x_re     (x_re),
    .x_im     (x_im),
    .y_re     (y_re),
    .y_im     (y_im),
    .p_re     (p_re),
    .p_im     (p_im),
    .p_re_ovf (p_re_ovf),
    .p_im_ovf (p_im_ovf)
  );

  // Register model: what each rank will hold after the coming edge
  logic [W-1:0]  m_a = '0, m_b = '0, m_c = '0, m_d = '0;
  bit            m_in_rst = 1'b1;
  logic [PW-1:0] e_re = '0, e_im = '0;
  logic          e_rov = 1'b0, e_iov = 1'b0;
  bit            e_rst = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arith(input logic [W-1:0] a, b, c, d,
                       output logic [PW-1:0] re, im, output logic rov, iov);
    int ai, bi, ci, di, r, i;
    ai = int'($signed(a)); bi = int'($signed(b));
    ci = int'($signed(c)); di = int'($signed(d));
    r = ai * ci - bi * di;
    i = ai * di + bi * ci;
    re  = r[PW-1:0];
    im  = i[PW-1:0];
    rov = (r > 127) || (r < -128);
    iov = (i > 127) || (i < -128);
  endtask

  task automatic step(input logic r, input logic [W-1:0] a, b, c, d);
    @(negedge clk);
    if (e_rst) begin
      chk("R6 p_re", 32'(p_re), 32'(e_re));
      chk("R6 p_im", 32'(p_im), 32'(e_im));
      chk("R6 flags", {30'd0, p_re_ovf, p_im_ovf}, {30'd0, e_rov, e_iov});
    end else begin
      chk("R1 p_re", 32'(p_re), 32'(e_re));
      chk("R2 p_im", 32'(p_im), 32'(e_im));
      chk("R3 p_re_ovf", 32'(p_re_ovf), 32'(e_rov));
      chk("R4 p_im_ovf", 32'(p_im_ovf), 32'(e_iov));
    end
    rst = r; x_re = a; x_im = b; y_re = c; y_im = d;
    if (r) begin
      e_re = '0; e_im = '0; e_rov = 1'b0; e_iov = 1'b0; e_rst = 1'b1;
      m_a = '0; m_b = '0; m_c = '0; m_d = '0; m_in_rst = 1'b1;
    end else begin
      arith(m_a, m_b, m_c, m_d, e_re, e_im, e_rov, e_iov);
      e_rst = m_in_rst;
      m_a = a; m_b = b; m_c = c; m_d = d; m_in_rst = 1'b0;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    // reset state (R6)
    step(1'b1, '0, '0, '0, '0);
    step(1'b1, 4'h3, 4'h5, 4'h9, 4'hA);
    step(1'b0, '0, '0, '0, '0);
    step(1'b0, '0, '0, '0, '0);

    // R7 worked example, with a one-edge latency probe (R5)
    step(1'b0, 4'h9, 4'hA, 4'h9, 4'hA);
    @(posedge clk); #1;
    chk("R5 still previous p_re", 32'(p_re), 32'd0);
    chk("R5 still previous p_im", 32'(p_im), 32'd0);
    step(1'b0, '0, '0, '0, '0);
    @(posedge clk); #1;
    chk("R7 p_re", 32'(p_re), 32'h0D);
    chk("R7 p_im", 32'(p_im), 32'h54);
    chk("R7 flags", {30'd0, p_re_ovf, p_im_ovf}, 32'd0);

    // R8 all components most negative
    step(1'b0, 4'h8, 4'h8, 4'h8, 4'h8);
    step(1'b0, 4'h1, 4'h2, 4'h3, 4'h4);
    @(posedge clk); #1;
    chk("R8 p_re", 32'(p_re), 32'h00);
    chk("R8 p_im", 32'(p_im), 32'h80);
    chk("R8 p_re_ovf", 32'(p_re_ovf), 32'd0);
    chk("R8 p_im_ovf", 32'(p_im_ovf), 32'd1);

    // Exhaustive streaming sweep (R1, R2, R3, R4, R5) with reset pulses (R6)
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] v;
      v = 16'(i);
      if (i == 3000 || i == 50000) begin
        step(1'b1, 4'h7, 4'h8, 4'h8, 4'h7);
        step(1'b1, 4'h8, 4'h8, 4'h8, 4'h8);
      end
      step(1'b0, v[3:0], v[7:4], v[11:8], v[15:12]);
    end
    step(1'b0, '0, '0, '0, '0);
    step(1'b0, '0, '0, '0, '0);
    step(1'b0, '0, '0, '0, '0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule